// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block holds the status word of an asynchronous serial port that supports a multiprocessor bit. Software reads and writes the word through a strobed 8-bit register interface. The transmit and receive datapaths report single-cycle events into the block: a buffer-to-shifter load, the last transmitted bit, the end of a reception with its stop-bit and parity results, and the received multiprocessor bit. A DMA-style transfer engine can also clear the data flags when it moves a byte. The block turns the flags into four interrupt requests, and each request has its own enable.

Software clears the five sticky flags (transmit-empty, receive-full, overrun, framing, parity) with a two-step handshake. It reads the word while the flag is 1, and its next write carries a 0 in that bit position. A write that does not follow such a read leaves the flag alone. The shift registers, baud timing and parity computation are outside the block, and only their results come in.

Top module: `sio_status_reg`

## Requirements
- R1: The status word has this bit order: 7 transmit-empty (TXE), 6 receive-full (RXF), 5 overrun (OVR), 4 framing error (FRM), 3 parity error (PAR), 2 transmit-end (TXD), 1 received mp bit (MPR), 0 mp bit to send (MPS). After reset the word reads 0x84.
- R2: A write clears bit n of bits 7..3 only when wdata[n] is 0 and the flag read as 1 in a read since the previous write. A flag that was 0 at that read, or a write with no read before it, is not cleared.
- R3: Writing 1 to any of bits 7..3 has no effect. Any write disarms every pending clear.
- R4: TXE sets whenever tx_en is 0 or tx_load pulses. TXD sets whenever tx_en is 0, or when tx_last_bit pulses while TXE is 1.
- R5: The clear handshake on bit 7, or a dma_tx_write pulse, clears both TXE and TXD.
- R6: RXF sets on rx_done when the stop bit is 1, the parity is good and RXF is 0. It clears through the handshake on bit 6 or on a dma_rx_read pulse.
- R7: OVR sets on rx_done while RXF is 1, and RXF stays 1.
- R8: FRM sets on rx_done with rx_stop_bit 0, and PAR sets on rx_done with rx_parity_err 1. Neither case sets RXF.
- R9: MPR loads rx_mpb on every rx_done and holds otherwise. Writes do not change TXD or MPR.
- R10: Bit 0 (MPS) takes wdata[0] on every write.
- R11: When a set event and a clear fall in the same cycle, the flag ends up 1.
- R12: irq_tx = TXE & irq_en[0], irq_rx = RXF & irq_en[1], irq_err = (OVR|FRM|PAR) & irq_en[2], irq_tend = TXD & irq_en[3].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Register read strobe; arms clears for flags that are 1 |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Current status word |
| tx_en | input | 1 | Transmitter enable |
| tx_load | input | 1 | Transmit data moved into the shifter |
| tx_last_bit | input | 1 | Last bit of a character is on the line |
| rx_done | input | 1 | A reception has ended |
| rx_stop_bit | input | 1 | Sampled stop-bit value of that reception |
| rx_parity_err | input | 1 | Parity mismatch for that reception |
| rx_mpb | input | 1 | Multiprocessor bit of that reception |
| dma_tx_write | input | 1 | DMA wrote the transmit data register |
| dma_rx_read | input | 1 | DMA read the receive data register |
| irq_en | input | 4 | Enables: 0 tx, 1 rx, 2 error, 3 transmit-end |
| irq_tx | output | 1 | Transmit-empty interrupt |
| irq_rx | output | 1 | Receive-full interrupt |
| irq_err | output | 1 | Error interrupt |
| irq_tend | output | 1 | Transmit-end interrupt |

## Verification
The assertions check on every cycle that each rise or fall of a flag has a legal cause. A transmit-end rise needs a disabled transmitter or a last bit while TXE is 1. An overrun rise needs a reception while RXF is 1. A framing-flag fall needs a zero write. The received mp bit holds between receptions, and a write leaves no clear armed. Only the bench scenarios can show the full read-then-write order: the partial clears with mixed write data, a stale arm taken while a flag was still 0, a set that beats a same-cycle clear, and the gating of the interrupts by their enables.

// File: rtl/sio_status_pkg.sv
// Shared constants for the serial status register: word width, bit
// positions that software decodes, reset value and the mask of
// flags that use the read-then-write-zero clear protocol.
package sio_status_pkg;
    localparam int REG_W  = 8;
    localparam int IRQ_W  = 4;
    localparam int B_TXE  = 7;
    localparam int B_RXF  = 6;
    localparam int B_OVR  = 5;
    localparam int B_FRM  = 4;
    localparam int B_PAR  = 3;
    localparam int B_TXD  = 2;
    localparam int B_MPR  = 1;
    localparam int B_MPS  = 0;
    localparam logic [REG_W-1:0] RESET_VAL = 8'h84;
    localparam logic [REG_W-1:0] CLR_MASK  = 8'hF8;
endpackage

// File: rtl/sio_arm_tracker.sv
// Records, per clearable flag, that the flag read as 1, and turns the
// next write into per-bit clear requests.
// Assumes rd_en and wr_en are single-cycle strobes. When both are high
// in one cycle, the write uses the arms recorded before that cycle.
module sio_arm_tracker #(
    parameter int              W    = 8,
    parameter logic [W-1:0]    MASK = 8'hF8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_en,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] flags,
    output logic [W-1:0] clr_req
);
    logic [W-1:0] arm_q;

    for (genvar i = 0; i < W; i++) begin : g_arm
        if (MASK[i]) begin : g_live
            // capture on read, drop on write, otherwise hold
            always_ff @(posedge clk) begin
                if (!rst_n)      arm_q[i] <= 1'b0;
                else if (rd_en)  arm_q[i] <= flags[i];
                else if (wr_en)  arm_q[i] <= 1'b0;
            end
            assign clr_req[i] = wr_en & arm_q[i] & ~wdata[i];
        end else begin : g_tied
            assign arm_q[i]   = 1'b0;
            assign clr_req[i] = 1'b0;
        end
    end

    // R3
    disarm_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en) |=> (arm_q == '0));
endmodule

// File: rtl/sio_status_flags.sv
// Holds the eight status bits. It applies the datapath set events, the
// software and DMA clear paths, and the rule that a set beats a clear.
// Assumes all event inputs are single-cycle pulses, except tx_en, which
// is a level.
module sio_status_flags
    import sio_status_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] clr_req,
    input  logic             tx_en,
    input  logic             tx_load,
    input  logic             tx_last_bit,
    input  logic             rx_done,
    input  logic             rx_stop_bit,
    input  logic             rx_parity_err,
    input  logic             rx_mpb,
    input  logic             dma_tx_write,
    input  logic             dma_rx_read,
    output logic [REG_W-1:0] flags
);
    logic [REG_W-1:0] set_v, clr_v;
    logic             tx_clear;

    // gather the set and clear causes per bit
    always_comb begin
        set_v    = '0;
        clr_v    = '0;
        tx_clear = clr_req[B_TXE] | dma_tx_write;
        set_v[B_TXE] = ~tx_en | tx_load;
        set_v[B_TXD] = ~tx_en | (tx_last_bit & flags[B_TXE]);
        set_v[B_RXF] = rx_done & rx_stop_bit & ~rx_parity_err & ~flags[B_RXF];
        set_v[B_OVR] = rx_done & flags[B_RXF];
        set_v[B_FRM] = rx_done & ~rx_stop_bit;
        set_v[B_PAR] = rx_done & rx_parity_err;
        clr_v[B_TXE] = tx_clear;
        clr_v[B_TXD] = tx_clear;
        clr_v[B_RXF] = clr_req[B_RXF] | dma_rx_read;
        clr_v[B_OVR] = clr_req[B_OVR];
        clr_v[B_FRM] = clr_req[B_FRM];
        clr_v[B_PAR] = clr_req[B_PAR];
    end

    for (genvar i = B_TXD; i < REG_W; i++) begin : g_flag
        // set has priority over clear
        always_ff @(posedge clk) begin
            if (!rst_n)        flags[i] <= RESET_VAL[i];
            else if (set_v[i]) flags[i] <= 1'b1;
            else if (clr_v[i]) flags[i] <= 1'b0;
        end
    end

    // received multiprocessor bit follows each reception
    always_ff @(posedge clk) begin
        if (!rst_n)       flags[B_MPR] <= RESET_VAL[B_MPR];
        else if (rx_done) flags[B_MPR] <= rx_mpb;
    end

    // multiprocessor bit to send is a plain software bit
    always_ff @(posedge clk) begin
        if (!rst_n)      flags[B_MPS] <= RESET_VAL[B_MPS];
        else if (wr_en)  flags[B_MPS] <= wdata[B_MPS];
    end

    // R4
    tend_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[B_TXD]) |-> $past(!tx_en || (tx_last_bit && flags[B_TXE])));
    // R7
    ovr_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[B_OVR]) |-> $past(rx_done && flags[B_RXF]));
    // R2
    frm_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags[B_FRM]) |-> $past(wr_en && !wdata[B_FRM]));
    // R9
    mpr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_done |=> $stable(flags[B_MPR]));
endmodule

// File: rtl/sio_irq_gen.sv
// Gates the status flags with the per-source enables to form the four
// interrupt requests. Purely combinational. Assumes the enables are
// levels.
module sio_irq_gen
    import sio_status_pkg::*;
(
    input  logic [REG_W-1:0] flags,
    input  logic [IRQ_W-1:0] irq_en,
    output logic [IRQ_W-1:0] irq
);
    // one request per source
    always_comb begin
        irq[0] = flags[B_TXE] & irq_en[0];
        irq[1] = flags[B_RXF] & irq_en[1];
        irq[2] = (flags[B_OVR] | flags[B_FRM] | flags[B_PAR]) & irq_en[2];
        irq[3] = flags[B_TXD] & irq_en[3];
    end
endmodule

// File: rtl/sio_status_reg.sv
// Top of the serial status flag register. It connects the clear-arm
// tracker, the flag store and the interrupt gating. Reads return the
// word with no wait cycle, and a write acts at the next clock edge.
module sio_status_reg
    import sio_status_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic             tx_en,
    input  logic             tx_load,
    input  logic             tx_last_bit,
    input  logic             rx_done,
    input  logic             rx_stop_bit,
    input  logic             rx_parity_err,
    input  logic             rx_mpb,
    input  logic             dma_tx_write,
    input  logic             dma_rx_read,
    input  logic [IRQ_W-1:0] irq_en,
    output logic             irq_tx,
    output logic             irq_rx,
    output logic             irq_err,
    output logic             irq_tend
);
    logic [REG_W-1:0] flags, clr_req;
    logic [IRQ_W-1:0] irq;

    sio_arm_tracker #(.W(REG_W), .MASK(CLR_MASK)) u_arm (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .flags(flags), .clr_req(clr_req)
    );

    sio_status_flags u_flags (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata),
        .clr_req(clr_req), .tx_en(tx_en), .tx_load(tx_load),
        .tx_last_bit(tx_last_bit), .rx_done(rx_done),
        .rx_stop_bit(rx_stop_bit), .rx_parity_err(rx_parity_err),
        .rx_mpb(rx_mpb), .dma_tx_write(dma_tx_write),
        .dma_rx_read(dma_rx_read), .flags(flags)
    );

    sio_irq_gen u_irq (.flags(flags), .irq_en(irq_en), .irq(irq));

    assign rdata    = flags;
    assign irq_tx   = irq[0];
    assign irq_rx   = irq[1];
    assign irq_err  = irq[2];
    assign irq_tend = irq[3];
endmodule

// File: tb/sio_status_reg_tb.sv
module sio_status_reg_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_en = 0, wr_en = 0, tx_en = 1, tx_load = 0, tx_last_bit = 0;
    logic       rx_done = 0, rx_stop_bit = 1, rx_parity_err = 0, rx_mpb = 0;
    logic       dma_tx_write = 0, dma_rx_read = 0;
    logic [7:0] wdata = 0, rdata;
    logic [3:0] irq_en = 4'hF;
    logic       irq_tx, irq_rx, irq_err, irq_tend;

    typedef struct {
        logic rd, wr, txen, txload, txlast, rxdone, stop, perr, mpb, dmatx, dmarx;
        logic [7:0] wd;
        logic [3:0] en;
    } stim_t;

    typedef struct {
        logic [7:0] rdata;
        logic [3:0] irq;
        string      tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_checks = 0, n_fail = 0;
    bit   done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sio_status_reg u_dut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .tx_en(tx_en), .tx_load(tx_load), .tx_last_bit(tx_last_bit),
        .rx_done(rx_done), .rx_stop_bit(rx_stop_bit), .rx_parity_err(rx_parity_err),
        .rx_mpb(rx_mpb), .dma_tx_write(dma_tx_write), .dma_rx_read(dma_rx_read),
        .irq_en(irq_en), .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err),
        .irq_tend(irq_tend)
    );

    function automatic stim_t idle();
        stim_t s;
        s.rd = 0; s.wr = 0; s.txen = 1; s.txload = 0; s.txlast = 0;
        s.rxdone = 0; s.stop = 1; s.perr = 0; s.mpb = 0; s.dmatx = 0;
        s.dmarx = 0; s.wd = 8'h00; s.en = 4'hF;
        return s;
    endfunction

    // driver: apply one cycle of stimulus, then queue the expected result
    task automatic step(input stim_t s, input logic [7:0] er, input logic [3:0] ei,
                        input string tag);
        exp_t e;
        @(negedge clk); #2;
        rd_en = s.rd; wr_en = s.wr; wdata = s.wd; tx_en = s.txen;
        tx_load = s.txload; tx_last_bit = s.txlast; rx_done = s.rxdone;
        rx_stop_bit = s.stop; rx_parity_err = s.perr; rx_mpb = s.mpb;
        dma_tx_write = s.dmatx; dma_rx_read = s.dmarx; irq_en = s.en;
        @(posedge clk); #1;
        rd_en = 0; wr_en = 0; tx_load = 0; tx_last_bit = 0; rx_done = 0;
        dma_tx_write = 0; dma_rx_read = 0; tx_en = 1;
        e.rdata = er; e.irq = ei; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // monitor: compare the oldest expectation at the falling edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            logic [3:0] got_irq;
            e = sb_q.pop_front();
            got_irq = {irq_tend, irq_err, irq_rx, irq_tx};
            n_checks++;
            if (rdata !== e.rdata) begin
                n_fail++;
                $display("FAIL %s rdata actual=%02h expected=%02h", e.tag, rdata, e.rdata);
            end
            n_checks++;
            if (got_irq !== e.irq) begin
                n_fail++;
                $display("FAIL %s irq actual=%04b expected=%04b", e.tag, got_irq, e.irq);
            end
        end
    end

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        stim_t s;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset value 0x84, irq {tend,err,rx,tx}
        s = idle();                           step(s, 8'h84, 4'b1001, "R1 reset");
        // R2 write without read
        s = idle(); s.wr = 1;                 step(s, 8'h84, 4'b1001, "R2 no read");
        s = idle(); s.rd = 1;                 step(s, 8'h84, 4'b1001, "R2 read");
        // R3 writing 1 keeps flag, disarms
        s = idle(); s.wr = 1; s.wd = 8'h80;   step(s, 8'h84, 4'b1001, "R3 write one");
        s = idle(); s.wr = 1;                 step(s, 8'h84, 4'b1001, "R3 disarmed");
        // R5 handshake clears TXE and TXD
        s = idle(); s.rd = 1;                 step(s, 8'h84, 4'b1001, "R5 read");
        s = idle(); s.wr = 1;                 step(s, 8'h00, 4'b0000, "R5 clear");
        // R10 mp bit to send
        s = idle(); s.wr = 1; s.wd = 8'h01;   step(s, 8'h01, 4'b0000, "R10 mps");
        // R4 last bit with TXE 0 does not set TXD
        s = idle(); s.txlast = 1;             step(s, 8'h01, 4'b0000, "R4 last no txe");
        s = idle(); s.txload = 1;             step(s, 8'h81, 4'b0001, "R4 load");
        s = idle(); s.txlast = 1;             step(s, 8'h85, 4'b1001, "R4 last");
        s = idle(); s.dmatx = 1;              step(s, 8'h01, 4'b0000, "R5 dma tx");
        s = idle(); s.txen = 0;               step(s, 8'h85, 4'b1001, "R4 tx off");
        // R11 set beats clear
        s = idle(); s.rd = 1;                 step(s, 8'h85, 4'b1001, "R11 read");
        s = idle(); s.wr = 1; s.wd = 8'h01; s.txload = 1;
                                              step(s, 8'h81, 4'b0001, "R11 set wins");
        s = idle(); s.dmatx = 1;              step(s, 8'h01, 4'b0000, "R5 dma tx2");
        // R6 receive good, R9 mp bit
        s = idle(); s.rxdone = 1; s.mpb = 1;  step(s, 8'h43, 4'b0010, "R6 rx good");
        s = idle(); s.rxdone = 1;             step(s, 8'h61, 4'b0110, "R7 overrun");
        s = idle(); s.dmarx = 1;              step(s, 8'h21, 4'b0100, "R6 dma rx");
        // R8 errors
        s = idle(); s.rxdone = 1; s.stop = 0; step(s, 8'h31, 4'b0100, "R8 framing");
        s = idle(); s.rxdone = 1; s.perr = 1; step(s, 8'h39, 4'b0100, "R8 parity");
        // R2 partial clear by write data
        s = idle(); s.rd = 1;                 step(s, 8'h39, 4'b0100, "R2 read err");
        s = idle(); s.wr = 1; s.wd = 8'h11;   step(s, 8'h11, 4'b0100, "R2 partial");
        s = idle(); s.wr = 1; s.wd = 8'h01;   step(s, 8'h11, 4'b0100, "R2 unarmed");
        s = idle(); s.rd = 1;                 step(s, 8'h11, 4'b0100, "R2 read frm");
        s = idle(); s.wr = 1; s.wd = 8'h01;   step(s, 8'h01, 4'b0000, "R2 clear frm");
        // R9 read-only bits ignore writes
        s = idle(); s.wr = 1; s.wd = 8'h06;   step(s, 8'h00, 4'b0000, "R9 ro write");
        // R12 enables gate requests
        s = idle(); s.rxdone = 1; s.mpb = 1; s.en = 4'h0;
                                              step(s, 8'h42, 4'b0000, "R12 all off");
        s = idle(); s.en = 4'b0010;           step(s, 8'h42, 4'b0010, "R12 rx only");
        // R6 software clear of RXF
        s = idle(); s.rd = 1;                 step(s, 8'h42, 4'b0010, "R6 read");
        s = idle(); s.wr = 1;                 step(s, 8'h02, 4'b0000, "R6 clear");
        // R2 stale arm: read while RXF 0, then set, then write 0
        s = idle(); s.rd = 1;                 step(s, 8'h02, 4'b0000, "R2 read zero");
        s = idle(); s.rxdone = 1;             step(s, 8'h40, 4'b0010, "R6 rx again");
        s = idle(); s.wr = 1;                 step(s, 8'h40, 4'b0010, "R2 stale arm");
        @(negedge clk); #1;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule